// File: doc/BRIEF.md
# Multi-context LUT logic row

This block is one row of a small programmable compute fabric that sits next to a group of data cache lines. The row has a fixed number of logic elements. Each element is a four-input look-up table. A switch box picks each table input from the operand words, from the left neighbour's latest result, or from the element's own result history. An optional carry mode chains neighbouring elements into a ripple adder. Every element keeps a short history of its own results, so a dependent operation can read an earlier result without a round trip through the cache.

The row holds one active configuration and several alternate configurations in context registers. A configuration is first loaded into the active register. Alternates can be written at any time without disturbing the active register. A per-cycle pick from the instruction decoder then copies any stored alternate into the active register. Evaluation happens on every clock edge where the execute enable is high, and the latest result of each element drives one bit of the result word.

Top module: `lut_ctx_row`

## Requirements
- R1: After reset, `res_o` is zero and every context register, active and alternate, holds all zeros. An enabled evaluation with that zero configuration therefore returns zero.
- R2: An element that is not in carry mode produces bit `tt[{in3,in2,in1,in0}]` of its 16-bit truth table. The value is captured at an enabled clock edge and appears on `res_o[i]` straight after that edge.
- R3: Each table input k has a 2-bit source code. Code 0 selects `opnd_a[i]`, code 1 selects `opnd_b[i]`, code 2 selects the left neighbour's latest result (constant 0 for element 0), and code 3 selects the element's own tapped history value.
- R4: Each element keeps its last four results and shifts them on every enabled edge. A 2-bit tap value t selects the result that is t+1 enabled edges old.
- R5: While `ex_en` is low, no result or history bit changes, whatever the operands are.
- R6: In carry mode, an element outputs its table bit XOR its carry-in, and passes `in0&in1 | cin&(in0^in1)` to the element on its right. Element 0 has carry-in 0, and an element not in carry mode passes carry 0. With table 16'h6666 and sources a, b, the row computes `(opnd_a + opnd_b) mod 2^N_LE`.
- R7: With `cfg_we` high, slot 0 writes the active register and slot k (1 to N_ALT) writes alternate k-1. A write to an alternate leaves the active register untouched. Element i uses bits `[27*i +: 27]` of `cfg_word`, laid out from MSB to LSB as: truth table (16), source codes for inputs 3..0 (2 each), tap (2), carry enable (1).
- R8: With `ctx_go` high and `ctx_pick` below N_ALT, the alternate named by `ctx_pick` is copied into the active register at that edge. The evaluation at that same edge still uses the old active configuration. If a slot-0 write happens in the same cycle, the switch wins. A pick value of N_ALT or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | $clog2(N_ALT+1) | 0 = active register, k = alternate k-1 |
| cfg_word | input | 27*N_LE | Full row configuration |
| ctx_go | input | 1 | Switch to an alternate context at this edge |
| ctx_pick | input | max(1,$clog2(N_ALT)) | Alternate index to switch to |
| ex_en | input | 1 | Evaluate and shift history at this edge |
| opnd_a | input | N_LE | First operand word, one bit per element |
| opnd_b | input | N_LE | Second operand word, one bit per element |
| res_o | output | N_LE | Latest result of each element |

## Verification
The bench builds the row with its default sizes: eight elements, three alternates and a four-deep history. Eight-bit operands make it possible to check the carry-chained adder over all 65,536 operand pairs, and to sweep the AND, OR and XOR tables over 256 pairs each. Three alternates with a 2-bit pick leave one unused pick code, so the case of an ignored switch can be driven. A bench-side model written from the requirements then follows a long pseudo-random mix of configuration writes, switches, enable gaps, history taps and carry chains.

// File: rtl/lut_row_pkg.sv
package lut_row_pkg;
  localparam int LUT_K  = 4;
  localparam int TT_W   = 1 << LUT_K;
  localparam int HIST_D = 4;
  localparam int TAP_W  = $clog2(HIST_D);
  localparam int SRC_W  = 2;

  localparam logic [SRC_W-1:0] SRC_OPA  = 2'd0;
  localparam logic [SRC_W-1:0] SRC_OPB  = 2'd1;
  localparam logic [SRC_W-1:0] SRC_LEFT = 2'd2;
  localparam logic [SRC_W-1:0] SRC_HIST = 2'd3;

  typedef struct packed {
    logic [TT_W-1:0]             tt;
    logic [LUT_K-1:0][SRC_W-1:0] src;
    logic [TAP_W-1:0]            tap;
    logic                        cy;
  } le_cfg_t;

  localparam int LE_CFG_W = $bits(le_cfg_t);
endpackage

// File: rtl/lut_sbox.sv
module lut_sbox
  import lut_row_pkg::*;
(
  input  logic                        opa,
  input  logic                        opb,
  input  logic                        left,
  input  logic                        hist,
  input  logic [LUT_K-1:0][SRC_W-1:0] src,
  output logic [LUT_K-1:0]            lin
);
  for (genvar k = 0; k < LUT_K; k++) begin : g_in
    always_comb begin
      unique case (src[k])
        SRC_OPA:  lin[k] = opa;
        SRC_OPB:  lin[k] = opb;
        SRC_LEFT: lin[k] = left;
        default:  lin[k] = hist;
      endcase
    end
  end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_row_pkg::*;
(
  input  logic [TT_W-1:0]  tt,
  input  logic [LUT_K-1:0] lin,
  input  logic             cy,
  input  logic             cin,
  output logic             out,
  output logic             cout
);
  logic lut_bit;
  logic gen;
  logic prop;

  always_comb begin
    lut_bit = tt[lin];
    gen     = lin[0] & lin[1];
    prop    = lin[0] ^ lin[1];
    out     = cy ? (lut_bit ^ cin) : lut_bit;
    cout    = cy & (gen | (prop & cin));
  end
endmodule

// File: rtl/lut_hist.sv
module lut_hist #(
  parameter int DEPTH = 4,
  parameter int TW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          d,
  input  logic [TW-1:0] tap,
  output logic          last,
  output logic          tapped
);
  logic [DEPTH-1:0] h_q;
  logic [DEPTH-1:0] h_d;

  always_comb begin
    h_d = h_q;
    if (en) h_d = {h_q[DEPTH-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_q <= '0;
    else        h_q <= h_d;
  end

  assign last   = h_q[0];
  assign tapped = h_q[tap];

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(h_q));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (h_q[DEPTH-1:1] == $past(h_q[DEPTH-2:0])));
endmodule

// File: rtl/lut_ctx_store.sv
module lut_ctx_store #(
  parameter int ROW_W = 216,
  parameter int N_ALT = 3,
  localparam int SLOT_W = $clog2(N_ALT + 1),
  localparam int PICK_W = (N_ALT > 1) ? $clog2(N_ALT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] slot,
  input  logic [ROW_W-1:0]  wdata,
  input  logic              go,
  input  logic [PICK_W-1:0] pick,
  output logic [ROW_W-1:0]  act_o
);
  logic [ROW_W-1:0]             act_q, act_d;
  logic [N_ALT-1:0][ROW_W-1:0]  alt_q, alt_d;
  logic [ROW_W-1:0]             alt_pick;
  logic                         go_ok;
  logic                         alt_wr;

  always_comb begin
    alt_pick = '0;
    go_ok    = 1'b0;
    for (int k = 0; k < N_ALT; k++) begin
      if (32'(pick) == k) begin
        alt_pick = alt_q[k];
        go_ok    = go;
      end
    end
  end

  always_comb begin
    act_d  = act_q;
    alt_d  = alt_q;
    alt_wr = we && (slot != '0);
    if (go_ok)                       act_d = alt_pick;
    else if (we && (slot == '0))     act_d = wdata;
    for (int k = 0; k < N_ALT; k++) begin
      if (we && (32'(slot) == k + 1)) alt_d[k] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      alt_q <= '0;
    end else begin
      act_q <= act_d;
      alt_q <= alt_d;
    end
  end

  assign act_o = act_q;

  p_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_ok |=> (act_q == $past(alt_pick)));

  p_alt_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_wr && !go) |=> $stable(act_q));
endmodule

// File: rtl/lut_ctx_row.sv
module lut_ctx_row
  import lut_row_pkg::*;
#(
  parameter int N_LE  = 8,
  parameter int N_ALT = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [$clog2(N_ALT+1)-1:0]            cfg_slot,
  input  logic [N_LE*LE_CFG_W-1:0]              cfg_word,
  input  logic                                  ctx_go,
  input  logic [((N_ALT>1)?$clog2(N_ALT):1)-1:0] ctx_pick,
  input  logic                                  ex_en,
  input  logic [N_LE-1:0]                       opnd_a,
  input  logic [N_LE-1:0]                       opnd_b,
  output logic [N_LE-1:0]                       res_o
);
  localparam int ROW_W = N_LE * LE_CFG_W;

  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [ROW_W-1:0] act_row;
  logic [N_LE:0]    cyc;
  logic [N_LE-1:0]  last;
  logic [N_LE-1:0]  tapped;
  logic [N_LE-1:0]  nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  lut_ctx_store #(.ROW_W(ROW_W), .N_ALT(N_ALT)) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .slot  (cfg_slot),
    .wdata (cfg_word),
    .go    (ctx_go),
    .pick  (ctx_pick),
    .act_o (act_row)
  );

  assign cyc[0] = 1'b0;

  for (genvar i = 0; i < N_LE; i++) begin : g_le
    le_cfg_t         cfg;
    logic            left_w;
    logic [LUT_K-1:0] lin;

    assign cfg = le_cfg_t'(act_row[i*LE_CFG_W +: LE_CFG_W]);

    if (i == 0) begin : g_edge
      assign left_w = 1'b0;
    end else begin : g_mid
      assign left_w = last[i-1];
    end

    lut_sbox u_sbox (
      .opa  (opnd_a[i]),
      .opb  (opnd_b[i]),
      .left (left_w),
      .hist (tapped[i]),
      .src  (cfg.src),
      .lin  (lin)
    );

    lut_cell u_cell (
      .tt   (cfg.tt),
      .lin  (lin),
      .cy   (cfg.cy),
      .cin  (cyc[i]),
      .out  (nxt[i]),
      .cout (cyc[i+1])
    );

    lut_hist #(.DEPTH(HIST_D), .TW(TAP_W)) u_hist (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .en     (ex_en),
      .d      (nxt[i]),
      .tap    (cfg.tap),
      .last   (last[i]),
      .tapped (tapped[i])
    );
  end

  assign res_o = last;

  p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ex_en |=> $stable(res_o));

  p_res_capture_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ex_en |=> (res_o == $past(nxt)));
endmodule

// File: tb/lut_ctx_row_bench.sv
module lut_ctx_row_bench;
  localparam int NL = 8;
  localparam int NA = 3;
  localparam int LW = 27;
  localparam int RW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_slot;
  logic [RW-1:0] cfg_word;
  logic          ctx_go;
  logic [1:0]    ctx_pick;
  logic          ex_en;
  logic [NL-1:0] opnd_a, opnd_b, res_o;

  always #5 clk = ~clk;

  lut_ctx_row #(.N_LE(NL), .N_ALT(NA)) u_lut_ctx_row (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_word(cfg_word), .ctx_go(ctx_go), .ctx_pick(ctx_pick),
    .ex_en(ex_en), .opnd_a(opnd_a), .opnd_b(opnd_b), .res_o(res_o)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [RW-1:0] m_act;
  logic [RW-1:0] m_alt [NA];
  logic [3:0]    m_h   [NL];
  logic [31:0]   rs = 32'h1234_5679;

  function automatic logic [LW-1:0] le(logic [15:0] tt, logic [1:0] s0, logic [1:0] s1,
                                       logic [1:0] s2, logic [1:0] s3, logic [1:0] tap, logic cy);
    return {tt, s3, s2, s1, s0, tap, cy};
  endfunction

  function automatic logic [RW-1:0] row(logic [LW-1:0] x);
    return {NL{x}};
  endfunction

  function automatic logic [NL-1:0] m_res();
    logic [NL-1:0] r;
    for (int i = 0; i < NL; i++) r[i] = m_h[i][0];
    return r;
  endfunction

  function automatic logic [31:0] xs(logic [31:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(string tag, logic [NL-1:0] exp);
    n_vec++;
    if (res_o !== exp) begin
      n_bad++;
      $display("FAIL %s: res_o=%02h expected %02h", tag, res_o, exp);
    end
  endtask

  task automatic step(logic [7:0] a, logic [7:0] b, logic en, logic we, logic [1:0] slot,
                      logic [RW-1:0] word, logic go, logic [1:0] pick);
    logic [NL-1:0] nres;
    logic          c;
    logic [RW-1:0] old_alt [NA];
    opnd_a = a; opnd_b = b; ex_en = en; cfg_we = we; cfg_slot = slot;
    cfg_word = word; ctx_go = go; ctx_pick = pick;
    c = 1'b0;
    for (int i = 0; i < NL; i++) begin
      logic [LW-1:0] cf;
      logic [3:0]    in;
      logic          l;
      cf = m_act[i*LW +: LW];
      for (int k = 0; k < 4; k++) begin
        case (cf[3+2*k +: 2])
          2'd0:    in[k] = a[i];
          2'd1:    in[k] = b[i];
          2'd2:    in[k] = (i == 0) ? 1'b0 : m_h[i-1][0];
          default: in[k] = m_h[i][cf[2:1]];
        endcase
      end
      l = cf[11 + in];
      if (cf[0]) begin
        nres[i] = l ^ c;
        c = (in[0] & in[1]) | (c & (in[0] ^ in[1]));
      end else begin
        nres[i] = l;
        c = 1'b0;
      end
    end
    if (en) for (int i = 0; i < NL; i++) m_h[i] = {m_h[i][2:0], nres[i]};
    for (int k = 0; k < NA; k++) old_alt[k] = m_alt[k];
    if (go && pick < 2'(NA)) m_act = old_alt[pick];
    else if (we && slot == 2'd0) m_act = word;
    if (we && slot != 2'd0) m_alt[slot-1] = word;
    @(posedge clk);
    #2;
  endtask

  task automatic run(logic [7:0] a, logic [7:0] b);
    step(a, b, 1'b1, 1'b0, 2'd0, '0, 1'b0, 2'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run incomplete, expected completion before limit");
    summary();
    $finish;
  end

  initial begin
    logic [NL-1:0] held;
    rst_n = 1'b0; cfg_we = 0; cfg_slot = 0; cfg_word = '0; ctx_go = 0; ctx_pick = 0;
    ex_en = 0; opnd_a = 0; opnd_b = 0;
    m_act = '0;
    for (int k = 0; k < NA; k++) m_alt[k] = '0;
    for (int i = 0; i < NL; i++) m_h[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk("R1 reset result", 8'h00);
    run(8'hFF, 8'hFF);
    chk("R1 zero config", 8'h00);

    // R2: AND / OR / XOR tables, sources a (code 0) and b (code 1)
    for (int f = 0; f < 3; f++) begin
      logic [15:0] tt;
      tt = (f == 0) ? 16'h8888 : (f == 1) ? 16'hEEEE : 16'h6666;
      step(8'h00, 8'h00, 1'b0, 1'b1, 2'd0, row(le(tt, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0)), 1'b0, 2'd0);
      for (int a = 0; a < 256; a++) begin
        logic [7:0] av, bv, ex;
        av = 8'(a); bv = 8'(a * 37 + 11);
        ex = (f == 0) ? (av & bv) : (f == 1) ? (av | bv) : (av ^ bv);
        run(av, bv);
        chk("R2 logic table", ex);
      end
    end

    // R6: carry chained adder, exhaustive
    step(8'h00, 8'h00, 1'b0, 1'b1, 2'd0, row(le(16'h6666, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 1'b1)), 1'b0, 2'd0);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        run(8'(a), 8'(b));
        chk("R6 add", 8'(a + b));
      end

    // R7: alternate writes while adder active
    step(8'h05, 8'h03, 1'b1, 1'b1, 2'd1, row(le(16'hAAAA, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0)), 1'b0, 2'd0);
    chk("R7 alt0 write keeps active", 8'h08);
    step(8'h06, 8'h03, 1'b1, 1'b1, 2'd2, row(le(16'hAAAA, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0)), 1'b0, 2'd0);
    chk("R7 alt1 write keeps active", 8'h09);

    // R8: switch to pass context; same edge still adds
    step(8'h5A, 8'h01, 1'b1, 1'b0, 2'd0, '0, 1'b1, 2'd0);
    chk("R8 switch edge uses old", 8'h5B);
    run(8'h81, 8'h00);
    chk("R8 pass after switch", 8'h81);

    // R3: left neighbour source
    step(8'h81, 8'h00, 1'b1, 1'b0, 2'd0, '0, 1'b1, 2'd1);
    chk("R3 pass before left", 8'h81);
    run(8'h00, 8'h00);
    chk("R3 left neighbour", 8'h02);
    run(8'hFF, 8'hFF);
    chk("R3 left neighbour", 8'h04);

    // R4: history taps
    for (int t = 0; t < 4; t++) begin
      step(8'h00, 8'h00, 1'b0, 1'b1, 2'd3, row(le(16'hAAAA, 2'd3, 2'd0, 2'd0, 2'd0, 2'(t), 1'b0)), 1'b1, 2'd0);
      for (int k = 0; k < 4; k++)
        step(8'(8'h11 * (k + 1)), 8'h00, 1'b1, 1'b0, 2'd0, '0, (k == 3), 2'd2);
      run(8'h00, 8'h00);
      chk("R4 history tap", 8'(8'h11 * (4 - t)));
    end

    // R5: enable low holds results
    step(8'h00, 8'h00, 1'b1, 1'b0, 2'd0, '0, 1'b1, 2'd0);
    run(8'h3C, 8'h00);
    held = res_o;
    step(8'hFF, 8'hAA, 1'b0, 1'b0, 2'd0, '0, 1'b0, 2'd0);
    chk("R5 enable low", held);
    step(8'h00, 8'h55, 1'b0, 1'b0, 2'd0, '0, 1'b0, 2'd0);
    chk("R5 enable low", held);

    // R8: switch beats same-cycle base write
    step(8'h12, 8'h0F, 1'b1, 1'b1, 2'd0, row(le(16'h6666, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0)), 1'b1, 2'd0);
    chk("R8 same-cycle edge", 8'h12);
    run(8'h77, 8'h0F);
    chk("R8 switch wins", 8'h77);

    // R8: pick code 3 ignored
    step(8'h10, 8'h00, 1'b1, 1'b0, 2'd0, '0, 1'b1, 2'd3);
    chk("R8 invalid pick edge", 8'h10);
    run(8'h20, 8'h00);
    chk("R8 invalid pick ignored", 8'h20);

    // R3 and R7: mixed pseudo-random traffic against the bench model
    for (int n = 0; n < 16000; n++) begin
      logic [RW-1:0] w;
      logic [31:0]   ctl;
      rs = xs(rs); ctl = rs;
      for (int i = 0; i < NL; i++) begin
        rs = xs(rs);
        w[i*LW +: LW] = rs[LW-1:0];
      end
      rs = xs(rs);
      step(rs[7:0], rs[15:8], (ctl[1:0] != 2'b00), (ctl[7:4] == 4'd0), ctl[9:8], w,
           (ctl[13:11] == 3'd0), ctl[15:14]);
      chk("R3 R7 model mix", m_res());
    end

    summary();
    $finish;
  end
endmodule